// File: doc/BRIEF.md
# FIFO Status and Edge-Triggered Interrupt Unit

This block sits beside the transmit and receive FIFOs and the shift engine of a serial flash/peripheral controller. Each cycle it gathers their level signals (occupancy counts, push/pop strobes and two transfer-engine flags) into one 12-bit status word. It derives the two FIFO "ready" flags by comparing occupancy against programmable threshold fields. It also keeps overflow and underflow as sticky flags.

Any status bit that goes from 0 to 1 latches a matching cause bit. Software clears cause bits by writing ones to them. A mask register gates the causes onto a single registered interrupt line. Because causes are taken from rising edges, a condition that is already true when software starts waiting never fires again, so software must check the status word before it arms the mask.

A flush request raises a flush strobe toward both FIFOs. The flush bit drops by itself once both FIFOs report zero occupancy, and it clears the sticky error flags at that point.

Top module: `fsi_status_irq`

## Requirements
- R1: Status word bit positions: 0 transfer done, 1 transfer ready, 2 receive ready, 3 transmit ready, 4 receive empty, 5 receive full, 6 transmit empty, 7 transmit full, 8 receive underflow, 9 receive overflow, 10 transmit underflow, 11 transmit overflow. Empty means occupancy 0 and full means occupancy equal to DEPTH.
- R2: Receive ready is 1 exactly when receive occupancy is greater than the receive threshold field (field = wanted byte count - 1). Transmit ready is 1 exactly when free transmit space (DEPTH - occupancy) is greater than the transmit threshold field (field = 7 - wanted byte count).
- R3: A cause bit is set only at the edge where its status bit goes from 0 to 1. A status bit that stays at 1 sets no further cause.
- R4: A write with ack_we_i clears every cause bit whose ack_data_i bit is 1. All ones clears all causes.
- R5: If a cause is set and acknowledged in the same cycle, the set wins and the cause stays 1.
- R6: irq_o is 1 exactly when some cause bit and its mask bit are both 1, and it changes at the same edge as cause_o or mask_o. A mask of zero keeps irq_o at 0.
- R7: A flush request raises flush_o at the next edge. flush_o stays high until the first edge at which both occupancies are 0, and it falls at that edge. A request while flush_o is already high has no effect.
- R8: An overflow (push while full) or underflow (pop while empty) sets its status bit, which stays 1 until a flush completes. It returns to 0 one edge after flush_o falls.
- R9: While reset is held, status_o, cause_o, mask_o, irq_o and flush_o are 0. The first status load after reset sets no cause.
- R10: An input condition sampled at clock edge k appears in status_o, and when it is a rising edge also in cause_o, right after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_level_i | input | CNT_W | Receive FIFO occupancy in bytes |
| tx_level_i | input | CNT_W | Transmit FIFO occupancy in bytes |
| rx_push_i | input | 1 | Receive FIFO write strobe |
| rx_pop_i | input | 1 | Receive FIFO read strobe |
| tx_push_i | input | 1 | Transmit FIFO write strobe |
| tx_pop_i | input | 1 | Transmit FIFO read strobe |
| xfer_done_i | input | 1 | Shift engine finished current word |
| xfer_rdy_i | input | 1 | Shift engine idle and ready |
| rx_thr_i | input | THR_W | Receive threshold field (count - 1) |
| tx_thr_i | input | THR_W | Transmit threshold field (7 - count) |
| flush_req_i | input | 1 | Request to flush both FIFOs |
| ack_we_i | input | 1 | Cause acknowledge write strobe |
| ack_data_i | input | 12 | Write-one-to-clear cause pattern |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 12 | New mask value |
| status_o | output | 12 | Registered status word |
| cause_o | output | 12 | Latched interrupt causes |
| mask_o | output | 12 | Current mask register |
| irq_o | output | 1 | Registered interrupt line |
| flush_o | output | 1 | Flush in progress, self-clearing |

## Verification
The threshold comparators are swept over every threshold field value against every occupancy from empty to full for both FIFOs. This separates the count-minus-one receive encoding from the seven-minus-count transmit encoding and exposes off-by-one compares at both ends. Cause behaviour is tried with a fresh rising edge, a level held high across several cycles, a drop-and-rise, an acknowledge in the same cycle as a rise, and a clear-all write. These tell edge capture apart from level capture and show which of set or clear takes priority. Flush is tried with the FIFOs still occupied and with them already empty. This separates waiting for completion from a fixed pulse and shows when the sticky error flags drop.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  localparam int ST_W = 12;
  localparam int B_XDONE  = 0;
  localparam int B_XRDY   = 1;
  localparam int B_RXRDY  = 2;
  localparam int B_TXRDY  = 3;
  localparam int B_RXEMP  = 4;
  localparam int B_RXFUL  = 5;
  localparam int B_TXEMP  = 6;
  localparam int B_TXFUL  = 7;
  localparam int B_RXUDF  = 8;
  localparam int B_RXOVF  = 9;
  localparam int B_TXUDF  = 10;
  localparam int B_TXOVF  = 11;
  typedef logic [ST_W-1:0] stat_t;
endpackage

// File: rtl/fsi_thr_cmp.sv
module fsi_thr_cmp #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  parameter int THR_W = 3,
  parameter bit IS_TX = 1'b0
) (
  input  logic [CNT_W-1:0] level_i,
  input  logic [THR_W-1:0] thr_i,
  output logic             rdy_o
);
  generate
    if (IS_TX) begin : g_tx
      // free space against threshold field
      always_comb begin
        int free_b;
        free_b = DEPTH - int'(level_i);
        rdy_o  = free_b > int'(thr_i);
      end
    end else begin : g_rx
      always_comb rdy_o = int'(level_i) > int'(thr_i);
    end
  endgenerate
endmodule

// File: rtl/fsi_err_track.sv
module fsi_err_track #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_level_i,
  input  logic [CNT_W-1:0] tx_level_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             tx_push_i,
  input  logic             tx_pop_i,
  input  logic             clr_i,
  output logic [3:0]       err_o   // {tx_ovf, tx_udf, rx_ovf, rx_udf}
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic [3:0] evt;
  logic [3:0] sticky_q;

  always_comb begin
    evt[0] = rx_pop_i  && (rx_level_i == '0);
    evt[1] = rx_push_i && (rx_level_i == FULL_LVL);
    evt[2] = tx_pop_i  && (tx_level_i == '0);
    evt[3] = tx_push_i && (tx_level_i == FULL_LVL);
  end

  always_ff @(posedge clk) begin
    if (rst)        sticky_q <= '0;
    else if (clr_i) sticky_q <= '0;
    else            sticky_q <= sticky_q | evt;
  end

  assign err_o = sticky_q | evt;
endmodule

// File: rtl/fsi_flush_ctl.sv
module fsi_flush_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic fifos_empty_i,
  output logic flush_o,
  output logic done_o
);
  logic flush_q;

  always_ff @(posedge clk) begin
    if (rst)          flush_q <= 1'b0;
    else if (flush_q) flush_q <= !fifos_empty_i;
    else              flush_q <= req_i;
  end

  assign flush_o = flush_q;
  assign done_o  = flush_q && fifos_empty_i;
endmodule

// File: rtl/fsi_cause_bank.sv
module fsi_cause_bank
  import fsi_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  stat_t status_d_i,
  input  logic  ack_we_i,
  input  stat_t ack_data_i,
  input  logic  mask_we_i,
  input  stat_t mask_data_i,
  output stat_t status_o,
  output stat_t cause_o,
  output stat_t mask_o,
  output logic  irq_o
);
  stat_t status_q, cause_q, mask_q, cause_d, mask_d;
  logic  primed_q, irq_q;

  generate
    for (genvar b = 0; b < ST_W; b++) begin : g_bit
      logic rise_b, clr_b;
      assign rise_b     = primed_q && status_d_i[b] && !status_q[b];
      assign clr_b      = ack_we_i && ack_data_i[b];
      assign cause_d[b] = (cause_q[b] && !clr_b) || rise_b;
    end
  endgenerate

  assign mask_d = mask_we_i ? mask_data_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      cause_q  <= '0;
      mask_q   <= '0;
      primed_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d_i;
      cause_q  <= cause_d;
      mask_q   <= mask_d;
      primed_q <= 1'b1;
      irq_q    <= |(cause_d & mask_d);
    end
  end

  assign status_o = status_q;
  assign cause_o  = cause_q;
  assign mask_o   = mask_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/fsi_status_irq.sv
module fsi_status_irq
  import fsi_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int THR_W = 3,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] rx_level_i,
  input  logic [CNT_W-1:0] tx_level_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             tx_push_i,
  input  logic             tx_pop_i,
  input  logic             xfer_done_i,
  input  logic             xfer_rdy_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic             flush_req_i,
  input  logic             ack_we_i,
  input  logic [11:0]      ack_data_i,
  input  logic             mask_we_i,
  input  logic [11:0]      mask_data_i,
  output logic [11:0]      status_o,
  output logic [11:0]      cause_o,
  output logic [11:0]      mask_o,
  output logic             irq_o,
  output logic             flush_o
);
  localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);

  logic       rx_rdy, tx_rdy, flush_done, fifos_empty;
  logic [3:0] err;
  stat_t      status_d;

  assign fifos_empty = (rx_level_i == '0) && (tx_level_i == '0);

  fsi_thr_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W), .IS_TX(1'b0)) u_rx_cmp (
    .level_i(rx_level_i), .thr_i(rx_thr_i), .rdy_o(rx_rdy));

  fsi_thr_cmp #(.DEPTH(DEPTH), .CNT_W(CNT_W), .THR_W(THR_W), .IS_TX(1'b1)) u_tx_cmp (
    .level_i(tx_level_i), .thr_i(tx_thr_i), .rdy_o(tx_rdy));

  fsi_flush_ctl u_flush (
    .clk(clk), .rst(rst), .req_i(flush_req_i), .fifos_empty_i(fifos_empty),
    .flush_o(flush_o), .done_o(flush_done));

  fsi_err_track #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_err (
    .clk(clk), .rst(rst),
    .rx_level_i(rx_level_i), .tx_level_i(tx_level_i),
    .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
    .tx_push_i(tx_push_i), .tx_pop_i(tx_pop_i),
    .clr_i(flush_done), .err_o(err));

  always_comb begin
    status_d          = '0;
    status_d[B_XDONE] = xfer_done_i;
    status_d[B_XRDY]  = xfer_rdy_i;
    status_d[B_RXRDY] = rx_rdy;
    status_d[B_TXRDY] = tx_rdy;
    status_d[B_RXEMP] = (rx_level_i == '0);
    status_d[B_RXFUL] = (rx_level_i == FULL_LVL);
    status_d[B_TXEMP] = (tx_level_i == '0);
    status_d[B_TXFUL] = (tx_level_i == FULL_LVL);
    status_d[B_RXUDF] = err[0];
    status_d[B_RXOVF] = err[1];
    status_d[B_TXUDF] = err[2];
    status_d[B_TXOVF] = err[3];
  end

  fsi_cause_bank u_bank (
    .clk(clk), .rst(rst), .status_d_i(status_d),
    .ack_we_i(ack_we_i), .ack_data_i(ack_data_i),
    .mask_we_i(mask_we_i), .mask_data_i(mask_data_i),
    .status_o(status_o), .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o));
endmodule

// File: rtl/fsi_status_irq_chk.sv
module fsi_status_irq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] rx_level_i,
  input logic [CNT_W-1:0] tx_level_i,
  input logic             ack_we_i,
  input logic [11:0]      ack_data_i,
  input logic [11:0]      status_o,
  input logic [11:0]      cause_o,
  input logic [11:0]      mask_o,
  input logic             irq_o,
  input logic             flush_o
);
  p_cause_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    ((cause_o & ~$past(cause_o)) & ~(status_o & ~$past(status_o))) == 12'h000);

  p_ack_clears_r4: assert property (@(posedge clk) disable iff (rst)
    ack_we_i |=> ((cause_o & $past(ack_data_i)) & ~(status_o & ~$past(status_o))) == 12'h000);

  p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq_o == |(cause_o & mask_o));

  p_flush_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (flush_o && rx_level_i == '0 && tx_level_i == '0) |=> !flush_o);

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (($past(status_o[11:8]) & ~status_o[11:8]) != 4'h0) |-> $past(flush_o, 2));
endmodule

bind fsi_status_irq fsi_status_irq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .rx_level_i(rx_level_i), .tx_level_i(tx_level_i),
  .ack_we_i(ack_we_i), .ack_data_i(ack_data_i), .status_o(status_o),
  .cause_o(cause_o), .mask_o(mask_o), .irq_o(irq_o), .flush_o(flush_o));

// File: tb/sim_fsi_status_irq.sv
`timescale 1ns/1ps
module sim_fsi_status_irq;
  localparam int DEPTH = 8;
  localparam int CNT_W = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic [CNT_W-1:0] rx_level, tx_level;
  logic rx_push, rx_pop, tx_push, tx_pop, xdone, xrdy, flush_req, ack_we, mask_we;
  logic [2:0] rx_thr, tx_thr;
  logic [11:0] ack_data, mask_data, status, cause, mask;
  logic irq, flush;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  fsi_status_irq #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .rx_level_i(rx_level), .tx_level_i(tx_level),
    .rx_push_i(rx_push), .rx_pop_i(rx_pop), .tx_push_i(tx_push), .tx_pop_i(tx_pop),
    .xfer_done_i(xdone), .xfer_rdy_i(xrdy), .rx_thr_i(rx_thr), .tx_thr_i(tx_thr),
    .flush_req_i(flush_req), .ack_we_i(ack_we), .ack_data_i(ack_data),
    .mask_we_i(mask_we), .mask_data_i(mask_data), .status_o(status),
    .cause_o(cause), .mask_o(mask), .irq_o(irq), .flush_o(flush));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // advance one edge; sample just after it
  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic ack(input logic [11:0] v);
    @(negedge clk); ack_we = 1; ack_data = v;
    step();
    ack_we = 0; ack_data = '0;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rx_level = 0; tx_level = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
    xdone = 0; xrdy = 0; flush_req = 0; ack_we = 0; mask_we = 0;
    ack_data = 0; mask_data = 0; rx_thr = 0; tx_thr = 0;
    repeat (3) step();
    // R9 reset values
    check("R9 status in reset", status, 0);
    check("R9 cause in reset", cause, 0);
    check("R9 irq/flush/mask in reset", {irq, flush, mask}, 0);
    @(negedge clk); rst = 0;
    step(); step();
    // both FIFOs empty: bits 4 and 6, tx ready (8 > 0) bit 3
    check("R1 R9 status after reset", status, 12'h058);
    check("R9 no cause from first load", cause, 0);

    // R2 sweep receive threshold
    for (int t = 0; t < 8; t++) begin
      for (int l = 0; l <= DEPTH; l++) begin
        @(negedge clk); rx_thr = 3'(t); rx_level = CNT_W'(l);
        step();
        check("R2 rx ready", status[2], (l > t) ? 1 : 0);
      end
    end
    // R2 sweep transmit threshold
    for (int t = 0; t < 8; t++) begin
      for (int l = 0; l <= DEPTH; l++) begin
        @(negedge clk); tx_thr = 3'(t); tx_level = CNT_W'(l);
        step();
        check("R2 tx ready", status[3], ((DEPTH - l) > t) ? 1 : 0);
      end
    end
    @(negedge clk); rx_level = 0; tx_level = 0; rx_thr = 7; tx_thr = 7;
    step();
    ack(12'hFFF);
    check("R4 clear all", cause, 0);

    // R1 R10 transfer flags
    @(negedge clk); xdone = 1;
    step();
    check("R10 R1 xfer done status", status[0], 1);
    check("R10 R1 xfer done cause", cause[0], 1);
    @(negedge clk); xdone = 0; xrdy = 1;
    step();
    check("R1 xfer ready status", status[1:0], 2'b10);
    ack(12'hFFF);

    // R3 edge capture
    @(negedge clk); rx_level = 8;
    step();
    check("R1 R3 rx full cause", cause[5], 1);
    check("R1 rx full status", status[5:4], 2'b10);
    ack(12'h020);
    check("R4 single ack", cause[5], 0);
    step(); step(); step();
    check("R3 held level no refire", cause[5], 0);
    @(negedge clk); rx_level = 7;
    step();
    @(negedge clk); rx_level = 8;
    step();
    check("R3 drop and rise refires", cause[5], 1);

    // R6 mask gating
    check("R6 mask zero keeps irq low", irq, 0);
    @(negedge clk); mask_we = 1; mask_data = 12'h020;
    step(); mask_we = 0;
    check("R6 irq follows mask", irq, 1);
    @(negedge clk); mask_we = 1; mask_data = 12'h001;
    step(); mask_we = 0;
    check("R6 other mask bit", irq, 0);
    @(negedge clk); mask_we = 1; mask_data = 12'h020;
    step(); mask_we = 0;
    ack(12'h020);
    check("R6 irq drops with cause", irq, 0);

    // R5 set beats ack
    @(negedge clk); rx_level = 7;
    step();
    ack(12'hFFF);
    @(negedge clk); rx_level = 8; ack_we = 1; ack_data = 12'h020;
    step(); ack_we = 0; ack_data = 0;
    check("R5 set wins over ack", cause[5], 1);
    check("R6 irq with set-win", irq, 1);
    ack(12'hFFF);
    check("R4 all-ones clears", cause, 0);

    // R8 overflow sticky
    @(negedge clk); rx_push = 1;
    step(); rx_push = 0;
    check("R8 rx overflow set", status[9], 1);
    check("R3 rx overflow cause", cause[9], 1);
    step(); step(); step();
    check("R8 overflow sticky", status[9], 1);

    // R7 flush waits for empty FIFOs
    @(negedge clk); flush_req = 1;
    step(); flush_req = 0;
    check("R7 flush raised", flush, 1);
    step(); step();
    check("R7 flush held while occupied", flush, 1);
    check("R8 sticky during flush", status[9], 1);
    @(negedge clk); rx_level = 0;
    step();
    check("R7 flush self-clears", flush, 0);
    step();
    check("R8 sticky cleared after flush", status[9], 0);

    // R8 underflow, flush with FIFOs already empty
    @(negedge clk); tx_pop = 1;
    step(); tx_pop = 0;
    check("R8 tx underflow set", status[10], 1);
    @(negedge clk); flush_req = 1;
    step(); flush_req = 0;
    check("R7 flush one cycle", flush, 1);
    step();
    check("R7 flush dropped", flush, 0);
    check("R8 still set on clear edge", status[10], 1);
    step();
    check("R8 underflow cleared", status[10], 0);

    finish_up();
  end
endmodule